// File: doc/BRIEF.md
# Iterative Shift-and-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and returns the full product of `2*WIDTH` bits. It handles one multiplier bit per clock cycle. A wide accumulator starts at zero. A multiplicand register of the same width holds the operand in its low half. On each step, the multiplicand register is added into the accumulator when the low bit of the multiplier register is one. The multiplicand register then moves one place left and the multiplier register moves one place right. A down-counter loaded with `WIDTH` ends the operation.

The caller raises `start_i` for one cycle while the block is idle, with both operands valid on the same cycle. The block then runs `WIDTH` steps and raises `done_o` for exactly one cycle. The product stays on `prod_o` until the next accepted start. Only one operation is in flight at a time, and any start seen while the block is busy is dropped.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `done_o` is 0, `busy_o` is 0 and `prod_o` is 0.
- R2: For any unsigned operands `a` (multiplicand) and `b` (multiplier), the value on `prod_o` while `done_o` is 1 equals `a*b`, written as `2*WIDTH` bits.
- R3: `done_o` rises exactly `WIDTH` clock edges after the edge that accepts `start_i`, and it is high for exactly one cycle.
- R4: A `start_i` pulse seen while `busy_o` is 1 has no effect. The running operation is not restarted, its result is unchanged, and a pulse that arrives during the `done_o` cycle does not begin a new operation.
- R5: After `done_o`, `prod_o` holds its value unchanged until the next accepted start.
- R6: On the cycle after a start is accepted, `prod_o` reads 0, because the accumulator is cleared on acceptance.
- R7: `busy_o` is 1 from the cycle after acceptance through the `done_o` cycle, and it is 0 on the cycle after `done_o`.
- R8: Boundary operands give exact results: a zero in either operand gives 0, and all-ones times all-ones gives `(2^WIDTH-1)^2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled only while idle |
| mcand_i | input | WIDTH | Multiplicand, unsigned |
| mplier_i | input | WIDTH | Multiplier, unsigned |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| busy_o | output | 1 | High while an operation is running or completing |
| prod_o | output | 2*WIDTH | Product (accumulator contents) |

## Verification
At `WIDTH` = 4, the bench sweeps every operand pair, so each multiplier bit pattern meets each multiplicand. This separates errors in the add decision, in the shift direction and in the step count, since each of those corrupts a different subset of products. At `WIDTH` = 8, random pairs plus the all-ones and zero corners exercise carries into the top half of the product. Separate directed runs inject start pulses during the run and during the done cycle, which tells a correctly ignored request apart from a restart or a reload.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_t;

endpackage

// File: rtl/shmul_ctrl.sv
module shmul_ctrl
  import shmul_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic done_o,
  output logic busy_o
);

  localparam int CW = $clog2(WIDTH + 1);

  mul_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign load_o    = start_i && (st_q == ST_IDLE);
  assign step_o    = (st_q == ST_RUN);
  assign last_step = step_o && (cnt_q == CW'(1));
  assign done_o    = (st_q == ST_DONE);
  assign busy_o    = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (load_o) begin
          st_q  <= ST_RUN;
          cnt_q <= CW'(WIDTH);
        end
        ST_RUN: begin
          cnt_q <= cnt_q - CW'(1);
          if (last_step) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R3
  done_count_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cnt_q == '0));

  // R4
  run_no_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (step_o && !last_step) |=> (step_o && cnt_q == $past(cnt_q) - CW'(1)));

  // R7
  done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);

endmodule

// File: rtl/shmul_dp.sv
module shmul_dp #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    acc_q;
  logic [PW-1:0]    mcd_q;
  logic [WIDTH-1:0] mpl_q;
  logic             add_en;

  function automatic logic [PW-1:0] cond_add(input logic [PW-1:0] acc,
                                             input logic [PW-1:0] addend,
                                             input logic          take);
    return take ? acc + addend : acc;
  endfunction

  function automatic logic [PW-1:0] widen(input logic [WIDTH-1:0] v);
    return {{WIDTH{1'b0}}, v};
  endfunction

  assign add_en = step_i && mpl_q[0];
  assign prod_o = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      mcd_q <= '0;
      mpl_q <= '0;
    end else if (load_i) begin
      acc_q <= '0;
      mcd_q <= widen(mcand_i);
      mpl_q <= mplier_i;
    end else if (step_i) begin
      acc_q <= cond_add(acc_q, mcd_q, add_en);
      mcd_q <= mcd_q << 1;
      mpl_q <= mpl_q >> 1;
    end
  end

  // R2
  skip_add_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !mpl_q[0]) |=> $stable(acc_q));

  // R2
  mcd_shift_chk: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (mcd_q == ($past(mcd_q) << 1)));

  // R5
  prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> $stable(acc_q));

  // R6
  clear_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (acc_q == '0));

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               done_o,
  output logic               busy_o,
  output logic [2*WIDTH-1:0] prod_o
);

  logic load_w;
  logic step_w;

  shmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load_w),
    .step_o  (step_w),
    .done_o  (done_o),
    .busy_o  (busy_o)
  );

  shmul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_w),
    .step_i   (step_w),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .prod_o   (prod_o)
  );

  // R4
  busy_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/sim_shift_add_mul.sv
`timescale 1ns/1ps
module sim_shift_add_mul;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks = 0;
  int   errors = 0;

  always #2.5 clk = ~clk;

  logic       s0 = 1'b0;
  logic [3:0] a0 = '0, b0 = '0;
  logic       d0, y0;
  logic [7:0] p0;

  logic       s1 = 1'b0;
  logic [7:0] a1 = '0, b1 = '0;
  logic       d1, y1;
  logic [15:0] p1;

  shift_add_mul #(.WIDTH(4)) u0 (
    .clk(clk), .rst(rst), .start_i(s0), .mcand_i(a0), .mplier_i(b0),
    .done_o(d0), .busy_o(y0), .prod_o(p0));

  shift_add_mul #(.WIDTH(8)) u1 (
    .clk(clk), .rst(rst), .start_i(s1), .mcand_i(a1), .mplier_i(b1),
    .done_o(d1), .busy_o(y1), .prod_o(p1));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_reset();
    chk(d0 == 1'b0 && d1 == 1'b0, "R1 done", d0, 0);
    chk(y0 == 1'b0 && y1 == 1'b0, "R1 busy", y0, 0);
    chk(p0 == 8'd0 && p1 == 16'd0, "R1 prod", p0, 0);
  endtask

  // One full operation on the 4-bit instance; optional stray starts
  task automatic mul4(input int a, input int b, input bit poke_run, input bit poke_done);
    int lat;
    int expv;
    logic [7:0] held;
    expv = a * b;
    @(negedge clk); s0 = 1'b1; a0 = 4'(a); b0 = 4'(b);
    @(negedge clk); s0 = 1'b0;
    chk(p0 == 8'd0, "R6 cleared", p0, 0);
    chk(y0 == 1'b1, "R7 busy after accept", y0, 1);
    lat = 0;
    while (!d0 && lat < 20) begin
      if (poke_run && lat == 1) begin s0 = 1'b1; a0 = ~a0; b0 = ~b0; end
      else s0 = 1'b0;
      @(negedge clk); lat++;
    end
    s0 = 1'b0;
    chk(lat == 4, "R3 latency", lat, 4);
    chk(p0 == 8'(expv), "R2 product", p0, expv);
    chk(y0 == 1'b1, "R7 busy in done", y0, 1);
    held = p0;
    if (poke_done) begin s0 = 1'b1; a0 = 4'hF; b0 = 4'hF; end
    @(negedge clk); s0 = 1'b0;
    chk(d0 == 1'b0, "R3 single pulse", d0, 0);
    chk(y0 == 1'b0, "R7/R4 idle after done", y0, 0);
    @(negedge clk);
    chk(p0 == held, "R5 hold", p0, held);
    chk(y0 == 1'b0, "R4 no restart", y0, 0);
  endtask

  task automatic mul8(input int a, input int b, input string tag);
    int lat;
    int expv;
    expv = a * b;
    @(negedge clk); s1 = 1'b1; a1 = 8'(a); b1 = 8'(b);
    @(negedge clk); s1 = 1'b0;
    lat = 0;
    while (!d1 && lat < 30) begin @(negedge clk); lat++; end
    chk(lat == 8, "R3 latency n8", lat, 8);
    chk(p1 == 16'(expv), tag, p1, expv);
    @(negedge clk);
    chk(d1 == 1'b0, "R3 pulse n8", d1, 0);
  endtask

  task automatic sweep4();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        mul4(a, b, 1'b0, 1'b0);
  endtask

  task automatic corners();
    mul4(9, 12, 1'b0, 1'b0);
    mul4(15, 15, 1'b0, 1'b0);   // R8
    mul4(0, 15, 1'b0, 1'b0);    // R8
    mul8(255, 255, "R8 all ones n8");
    mul8(0, 200, "R8 zero n8");
    mul8(173, 0, "R8 zero multiplier n8");
  endtask

  task automatic stray_starts();
    mul4(11, 13, 1'b1, 1'b0);   // R4 start during run
    mul4(7, 5, 1'b0, 1'b1);     // R4 start during done cycle
    mul4(6, 9, 1'b1, 1'b1);     // R4 both
  endtask

  task automatic random8();
    for (int i = 0; i < 200; i++)
      mul8(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), "R2 product n8");
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_reset();
    corners();
    stray_starts();
    sweep4();
    random8();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule